// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a three-bit state register that walks a fixed, non-binary loop of five codes: 000, 010, 011, 101, 110, then 000 again. Each bit of the next state comes from a short sum-of-products equation over the present state. The three codes that are not in the loop are not left to chance: each one has a defined successor, so a register that wakes up at any value joins the loop within two enabled clocks. No reset is needed for that.

The counter advances on a rising clock edge while its enable is high and holds while the enable is low. A synchronous active-low reset loads a start code. The start code is a parameter and is 000 by default. The present code is driven straight out, together with a flag that is high while the register sits on one of the three codes outside the loop. A second parameter chooses how the next-state logic is written: either as the three bit equations or as a full eight-entry case table. Both forms give the same transitions.

Top module: `ssc_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state loads the parameter `RST_CODE` (default 000). After a reset with the default, `state_o` is 000 and `bad_o` is 0.
- R2: While `rst_n` is high and `en` is low, `state_o` keeps its value across rising edges. This holds for codes in the loop and for codes outside it.
- R3: With `en` high, the state steps 000 → 010 → 011 → 101 → 110 → 000, one step per edge. `state_o[2]` is C, `state_o[1]` is B and `state_o[0]` is A.
- R4: With `en` high, code 001 is followed by 110.
- R5: With `en` high, code 100 is followed by 010.
- R6: With `en` high, code 111 is followed by 100, and then by 010.
- R7: `bad_o` is 1 exactly when `state_o` is 001, 100 or 111, and 0 for the five codes in the loop.
- R8: From any start code, at most two enabled edges bring the state into the loop. Once in the loop, it never leaves while enabled.
- R9: Reset takes priority over `en`. A low `rst_n` loads `RST_CODE` even when `en` is high.
- R10: With `NS_STYLE` = 1 (case-table form), the loop order is the same as with `NS_STYLE` = 0 (equation form).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `RST_CODE` |
| en | input | 1 | Count enable; low holds the state |
| state_o | output | 3 | Present code {C, B, A} |
| bad_o | output | 1 | High while the code is outside the five-code loop |

## Verification
The bench starts extra instances at each unused code (001, 100 and 111) through the `RST_CODE` parameter. It then checks the exact successor of each code and the two-step path out of 111. A design that left the unused codes as don't-cares would lock up or circle among 001, 100 and 111, and these checks would see the wrong code. It also holds the enable low while the state is on an unused code, to catch logic that escapes on its own without an enable. It runs reset with the enable high, to catch reset being lost to counting. Finally it walks the loop several times in both next-state forms, where a single wrong product term shows up as a skipped or repeated code.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int STATE_W = 3;
  localparam int LOOP_LEN = 5;
  typedef logic [STATE_W-1:0] code_t;

  localparam code_t CODE_S0 = 3'b000;
  localparam code_t CODE_S1 = 3'b010;
  localparam code_t CODE_S2 = 3'b011;
  localparam code_t CODE_S3 = 3'b101;
  localparam code_t CODE_S4 = 3'b110;

  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;
endpackage

// File: rtl/ssc_next.sv
module ssc_next
  import ssc_pkg::*;
#(
  parameter int NS_STYLE = 0
) (
  input  code_t cur_i,
  output code_t nxt_o
);
  generate
    if (NS_STYLE == 0) begin : g_eqn
      logic c_b, b_b, a_b;
      assign c_b = cur_i[BIT_C];
      assign b_b = cur_i[BIT_B];
      assign a_b = cur_i[BIT_A];
      always_comb begin
        nxt_o        = '0;
        nxt_o[BIT_C] = a_b;
        nxt_o[BIT_B] = ~b_b | (~a_b & ~c_b);
        nxt_o[BIT_A] = b_b & ~c_b;
      end
    end else begin : g_table
      always_comb begin
        unique case (cur_i)
          3'b000:  nxt_o = 3'b010;
          3'b001:  nxt_o = 3'b110;
          3'b010:  nxt_o = 3'b011;
          3'b011:  nxt_o = 3'b101;
          3'b100:  nxt_o = 3'b010;
          3'b101:  nxt_o = 3'b110;
          3'b110:  nxt_o = 3'b000;
          default: nxt_o = 3'b100;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ssc_flag.sv
module ssc_flag
  import ssc_pkg::*;
(
  input  code_t cur_i,
  output logic  bad_o
);
  always_comb begin
    unique case (cur_i)
      CODE_S0, CODE_S1, CODE_S2, CODE_S3, CODE_S4: bad_o = 1'b0;
      default:                                     bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ssc_reg.sv
module ssc_reg
  import ssc_pkg::*;
#(
  parameter code_t RST_CODE = CODE_S0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  code_t nxt_i,
  output code_t q_o
);
  code_t d_w;

  always_comb begin
    if (!rst_n)  d_w = RST_CODE;
    else if (en) d_w = nxt_i;
    else         d_w = q_o;
  end

  always_ff @(posedge clk) begin
    q_o <= d_w;
  end
endmodule

// File: rtl/ssc_top.sv
module ssc_top
  import ssc_pkg::*;
#(
  parameter logic [2:0] RST_CODE = 3'b000,
  parameter int         NS_STYLE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [2:0] state_o,
  output logic       bad_o
);
  code_t cur_w, nxt_w;

  ssc_next #(.NS_STYLE(NS_STYLE)) u_next (.cur_i(cur_w), .nxt_o(nxt_w));
  ssc_reg  #(.RST_CODE(RST_CODE)) u_reg  (.clk(clk), .rst_n(rst_n), .en(en),
                                          .nxt_i(nxt_w), .q_o(cur_w));
  ssc_flag u_flag (.cur_i(cur_w), .bad_o(bad_o));

  assign state_o = cur_w;
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter logic [2:0] RST_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] state_o,
  input logic       bad_o
);
  // R1 / R9: a low reset loads the start code, whatever en is
  assert_reset_load_R1: assert property (@(posedge clk)
    !rst_n |=> state_o == RST_CODE);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_o));

  assert_loop_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && state_o == 3'b110 |=> state_o == 3'b000);

  assert_from_001_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && state_o == 3'b001 |=> state_o == 3'b110);

  assert_from_100_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && state_o == 3'b100 |=> state_o == 3'b010);

  assert_from_111_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && state_o == 3'b111 |=> state_o == 3'b100);

  assert_flag_on_000_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'b000 |-> !bad_o);

  assert_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && bad_o |=> !bad_o || state_o == 3'b100);

  assert_stay_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && !bad_o |=> !bad_o);
endmodule

bind ssc_top ssc_chk #(.RST_CODE(RST_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .state_o(state_o), .bad_o(bad_o));

// File: tb/tb_ssc_top.sv
module tb_ssc_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk;
  logic rst_n;
  logic en;
  logic [2:0] st_d, st_t, st_1, st_4, st_7;
  logic       bd_d, bd_t, bd_1, bd_4, bd_7;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  ssc_top dut (.clk(clk), .rst_n(rst_n), .en(en), .state_o(st_d), .bad_o(bd_d));
  ssc_top #(.NS_STYLE(1)) u_tab (.clk(clk), .rst_n(rst_n), .en(en),
                                 .state_o(st_t), .bad_o(bd_t));
  ssc_top #(.RST_CODE(3'b001)) u_s001 (.clk(clk), .rst_n(rst_n), .en(en),
                                       .state_o(st_1), .bad_o(bd_1));
  ssc_top #(.RST_CODE(3'b100)) u_s100 (.clk(clk), .rst_n(rst_n), .en(en),
                                       .state_o(st_4), .bad_o(bd_4));
  ssc_top #(.RST_CODE(3'b111)) u_s111 (.clk(clk), .rst_n(rst_n), .en(en),
                                       .state_o(st_7), .bad_o(bd_7));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2:0] loop_next(input logic [2:0] c);
    case (c)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  // R1, R7: start codes and flags after reset
  task automatic t_reset();
    en = 1'b0;
    do_reset();
    chk("R1 default start", {bd_d, st_d}, 4'b0_000);
    chk("R7 flag on 001",   {bd_1, st_1}, 4'b1_001);
    chk("R7 flag on 100",   {bd_4, st_4}, 4'b1_100);
    chk("R7 flag on 111",   {bd_7, st_7}, 4'b1_111);
  endtask

  // R2: en low holds valid and unused codes
  task automatic t_hold();
    en = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk("R2 hold valid", {bd_d, st_d}, 4'b0_000);
    chk("R2 hold 001",   {bd_1, st_1}, 4'b1_001);
    chk("R2 hold 111",   {bd_7, st_7}, 4'b1_111);
  endtask

  // R4, R5, R6, R8: recovery from each unused code
  task automatic t_recover();
    en = 1'b0;
    do_reset();
    en = 1'b1;
    step();
    chk("R4 001 to 110", {bd_1, st_1}, 4'b0_110);
    chk("R5 100 to 010", {bd_4, st_4}, 4'b0_010);
    chk("R6 111 to 100", {bd_7, st_7}, 4'b1_100);
    step();
    chk("R6 100 to 010", {bd_7, st_7}, 4'b0_010);
    chk("R8 001 stays valid", {3'b000, bd_1}, 4'b0000);
    chk("R8 100 stays valid", {3'b000, bd_4}, 4'b0000);
    en = 1'b0;
  endtask

  // R3, R7, R10: walk the loop in both next-state forms
  task automatic t_cycle();
    logic [2:0] exp;
    en = 1'b0;
    do_reset();
    exp = 3'b000;
    en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step();
      exp = loop_next(exp);
      chk("R3 loop order", {bd_d, st_d}, {1'b0, exp});
      chk("R10 table form", {bd_t, st_t}, {1'b0, exp});
    end
    en = 1'b0;
  endtask

  // R9: reset wins over enable
  task automatic t_rst_prio();
    en = 1'b1;
    step();
    step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R9 reset over en", {bd_d, st_d}, 4'b0_000);
    chk("R9 reset over en seed", {bd_7, st_7}, 4'b1_111);
    en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    step();
    t_reset();
    t_hold();
    t_recover();
    t_cycle();
    t_rst_prio();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule